// File: doc/BRIEF.md
# Byte Adder with Condition Flags

This block executes the two byte-add instructions of a small 8-bit processor core. It accepts a 16-bit instruction word together with the two register values that the register file has already read. It checks whether the word is a plain add or an add that also takes in the incoming carry. If it is, it forms the byte sum and a fresh status byte. The status byte carries six arithmetic flags, and the interrupt-enable and user-transfer bits pass through it unchanged.

The result appears one clock after the word is presented. It comes with strobes that tell the register file which register to write and tell the fetch unit to advance the program counter by one word. The register file and the instruction fetch sit outside the block.

The register indices are split across the instruction word. The block reassembles them and reports both indices. When both indices name the same register, the core feeds equal operands, and the add then acts as a one-bit left shift.

Top module: `add8_flag_unit`

## Requirements
- R1: A word whose upper six bits are 000011 is a plain add. A word whose upper six bits are 000111 is an add that also adds the incoming carry (status bit 0) into bit 0 of the sum. Every other word is not recognised.
- R2: The destination index is {instr[8], instr[7:4]} and the source index is {instr[9], instr[3:0]}. Both are reported on the cycle after acceptance, and both cover the range 0 to 31.
- R3: On the clock after a valid recognised word, res_valid is high and res_data holds (rd_val + rr_val + carry-in) modulo 256. The carry-in is zero for the plain add.
- R4: Status bit 0 (C) is set exactly when the addition carries out of bit 7.
- R5: Status bit 1 (Z) is set exactly when the byte result is 0x00.
- R6: Status bit 2 (N) equals result bit 7. Status bit 3 (V) is set exactly when both operands share bit 7 and the result's bit 7 differs from it.
- R7: Status bit 4 (S) equals N XOR V.
- R8: Status bit 5 (H) is set exactly when the addition carries out of bit 3, with the incoming carry included for the carry variant.
- R9: Status bits 7 and 6 of sreg_out equal bits 7 and 6 of sreg_in as sampled with the instruction.
- R10: pc_step is high for exactly one cycle per accepted instruction, in the same cycle as res_valid, and asks for an advance of one word.
- R11: An unrecognised word, or a cycle with instr_valid low, leaves res_valid, sreg_wr and pc_step low on the next cycle. res_data and sreg_out then keep their previous values.
- R12: While rst is high and on the cycle after it, res_valid, sreg_wr and pc_step are low, and res_data, sreg_out, dst_idx and src_idx are zero.
- R13: With equal destination and source indices and equal operands, the result is the operand shifted left by one. C takes the old bit 7, and the other flags follow R5 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word and operands are present this cycle |
| instr | input | 16 | Instruction word |
| rd_val | input | 8 | Value of the destination register |
| rr_val | input | 8 | Value of the source register |
| sreg_in | input | 8 | Current status byte |
| res_valid | output | 1 | Result write strobe |
| res_data | output | 8 | Byte sum |
| dst_idx | output | 5 | Destination register index |
| src_idx | output | 5 | Source register index |
| sreg_wr | output | 1 | Status byte write strobe |
| sreg_out | output | 8 | New status byte |
| pc_step | output | 1 | Advance program counter by one word |

## Verification
The bench goes after the flag boundaries. It covers a carry out of bit 3 with no carry out of bit 7, overflow at 0x7F+0x01 and at 0x80+0x80, and a zero result that arrives together with a carry. A wrong half-carry tap, or an overflow built from the carry out alone, would show up as a flipped H or V bit in those cases. For the carry variant, 0xFF+0x00 with carry set must wrap to zero with H, Z and C set, so a design that dropped the carry-in would report 0xFF instead. Split-field words with the high index bits set, self-adds, and neighbouring opcodes that are not recognised round out the cases. These catch a swapped index bit, and they catch strobes or held outputs that change on a word the block does not handle.

// File: rtl/add8_pkg.sv
package add8_pkg;

    localparam int DATA_W   = 8;
    localparam int IDX_W    = 5;
    localparam int INSTR_W  = 16;
    localparam int PREFIX_W = 6;

    localparam logic [PREFIX_W-1:0] PFX_ADD  = 6'b000011;
    localparam logic [PREFIX_W-1:0] PFX_ADDC = 6'b000111;

    localparam int SB_C = 0;
    localparam int SB_Z = 1;
    localparam int SB_N = 2;
    localparam int SB_V = 3;
    localparam int SB_S = 4;
    localparam int SB_H = 5;
    localparam int SB_T = 6;
    localparam int SB_I = 7;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_ADD  = 2'd1,
        OPK_ADDC = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e             kind;
        logic [IDX_W-1:0]     dst;
        logic [IDX_W-1:0]     src;
    } dec_t;

    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } arith_flags_t;

    function automatic op_kind_e classify(input logic [PREFIX_W-1:0] pfx);
        op_kind_e k;
        case (pfx)
            PFX_ADD:  k = OPK_ADD;
            PFX_ADDC: k = OPK_ADDC;
            default:  k = OPK_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [7:0] merge_status(input logic [7:0] old,
                                                input arith_flags_t f);
        logic [7:0] r;
        r       = old;
        r[SB_C] = f.c;
        r[SB_Z] = f.z;
        r[SB_N] = f.n;
        r[SB_V] = f.v;
        r[SB_S] = f.s;
        r[SB_H] = f.h;
        return r;
    endfunction

endpackage

// File: rtl/add8_decode.sv
module add8_decode
    import add8_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int XW = IDX_W
) (
    input  logic [IW-1:0] word,
    output dec_t          dec
);
    localparam int LOW_W = XW - 1;

    logic [LOW_W-1:0] dst_low;
    logic [LOW_W-1:0] src_low;

    assign dst_low = word[2*LOW_W-1:LOW_W];
    assign src_low = word[LOW_W-1:0];

    always_comb begin
        dec.kind = classify(word[IW-1:IW-PREFIX_W]);
        dec.dst  = {word[2*LOW_W], dst_low};
        dec.src  = {word[2*LOW_W+1], src_low};
    end
endmodule

// File: rtl/add8_ripple.sv
module add8_ripple #(
    parameter int W        = 8,
    parameter int HALF_BIT = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_half,
    output logic         c_into_msb,
    output logic         c_out
);
    logic [W:0] cy;

    assign cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p;
        assign p         = a[i] ^ b[i];
        assign sum[i]    = p ^ cy[i];
        assign cy[i+1]   = (a[i] & b[i]) | (cy[i] & p);
    end

    assign c_half     = cy[HALF_BIT+1];
    assign c_into_msb = cy[W-1];
    assign c_out      = cy[W];
endmodule

// File: rtl/add8_flags.sv
module add8_flags
    import add8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]  sum,
    input  logic          c_half,
    input  logic          c_into_msb,
    input  logic          c_out,
    output arith_flags_t  flags
);
    logic ovf;

    assign ovf = c_into_msb ^ c_out;

    always_comb begin
        flags.c = c_out;
        flags.z = ~|sum;
        flags.n = sum[W-1];
        flags.v = ovf;
        flags.s = sum[W-1] ^ ovf;
        flags.h = c_half;
    end
endmodule

// File: rtl/add8_flag_unit.sv
module add8_flag_unit
    import add8_pkg::*;
#(
    parameter int DW       = DATA_W,
    parameter int XW       = IDX_W,
    parameter int IW       = INSTR_W,
    parameter int HALF_BIT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_valid,
    input  logic [15:0]   instr,
    input  logic [7:0]    rd_val,
    input  logic [7:0]    rr_val,
    input  logic [7:0]    sreg_in,
    output logic          res_valid,
    output logic [7:0]    res_data,
    output logic [4:0]    dst_idx,
    output logic [4:0]    src_idx,
    output logic          sreg_wr,
    output logic [7:0]    sreg_out,
    output logic          pc_step
);
    dec_t          dec;
    logic          take;
    logic          cin;
    logic [DW-1:0] sum;
    logic          c_half;
    logic          c_into_msb;
    logic          c_out;
    arith_flags_t  flags;
    logic [7:0]    status_nx;

    add8_decode #(.IW(IW), .XW(XW)) u_dec (
        .word (instr),
        .dec  (dec)
    );

    assign take = instr_valid && (dec.kind != OPK_NONE);
    assign cin  = (dec.kind == OPK_ADDC) && sreg_in[SB_C];

    add8_ripple #(.W(DW), .HALF_BIT(HALF_BIT)) u_add (
        .a          (rd_val),
        .b          (rr_val),
        .cin        (cin),
        .sum        (sum),
        .c_half     (c_half),
        .c_into_msb (c_into_msb),
        .c_out      (c_out)
    );

    add8_flags #(.W(DW)) u_flg (
        .sum        (sum),
        .c_half     (c_half),
        .c_into_msb (c_into_msb),
        .c_out      (c_out),
        .flags      (flags)
    );

    assign status_nx = merge_status(sreg_in, flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            sreg_wr   <= 1'b0;
            pc_step   <= 1'b0;
            res_data  <= '0;
            sreg_out  <= '0;
            dst_idx   <= '0;
            src_idx   <= '0;
        end else begin
            res_valid <= take;
            sreg_wr   <= take;
            pc_step   <= take;
            if (take) begin
                res_data <= sum;
                sreg_out <= status_nx;
                dst_idx  <= dec.dst;
                src_idx  <= dec.src;
            end
        end
    end
endmodule

// File: rtl/add8_flag_unit_chk.sv
module add8_flag_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [15:0] instr,
    input logic [7:0]  rd_val,
    input logic [7:0]  rr_val,
    input logic [7:0]  sreg_in,
    input logic        res_valid,
    input logic [7:0]  res_data,
    input logic        sreg_wr,
    input logic [7:0]  sreg_out,
    input logic        pc_step
);
    logic known_op;
    assign known_op = (instr[15:10] == 6'b000011) || (instr[15:10] == 6'b000111);

    a_r11_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (!instr_valid || !known_op) |=> (!res_valid && !sreg_wr && !pc_step));

    a_r3_sum: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ({sreg_out[0], res_data} ==
            (9'($past(rd_val)) + 9'($past(rr_val)) +
             9'($past(instr[12]) & $past(sreg_in[0])))));

    a_r5_zero: assert property (@(posedge clk) disable iff (rst)
        sreg_wr |-> (sreg_out[1] == (res_data == 8'h00)));

    a_r6_negative: assert property (@(posedge clk) disable iff (rst)
        sreg_wr |-> (sreg_out[2] == res_data[7]));

    a_r7_sign: assert property (@(posedge clk) disable iff (rst)
        sreg_wr |-> (sreg_out[4] == (sreg_out[2] ^ sreg_out[3])));

    a_r9_passthru: assert property (@(posedge clk) disable iff (rst)
        sreg_wr |-> (sreg_out[7:6] == $past(sreg_in[7:6])));

    a_r10_pc_step: assert property (@(posedge clk) disable iff (rst)
        pc_step |-> (res_valid && sreg_wr));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(res_data) && $stable(sreg_out)));

    a_r12_reset: assert property (@(posedge clk)
        rst |=> (!res_valid && !sreg_wr && !pc_step));
endmodule

bind add8_flag_unit add8_flag_unit_chk chk_i (.*);

// File: tb/add8_flag_unit_tb_top.sv
module add8_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [7:0]  rd_val = '0;
    logic [7:0]  rr_val = '0;
    logic [7:0]  sreg_in = '0;
    logic        res_valid;
    logic [7:0]  res_data;
    logic [4:0]  dst_idx;
    logic [4:0]  src_idx;
    logic        sreg_wr;
    logic [7:0]  sreg_out;
    logic        pc_step;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] last_res  = '0;
    logic [7:0] last_sreg = '0;

    always #5 clk = ~clk;

    add8_flag_unit dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .rd_val(rd_val), .rr_val(rr_val), .sreg_in(sreg_in),
        .res_valid(res_valid), .res_data(res_data), .dst_idx(dst_idx),
        .src_idx(src_idx), .sreg_wr(sreg_wr), .sreg_out(sreg_out),
        .pc_step(pc_step)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input bit carry, input int d, input int r);
        logic [4:0] dd, rr;
        dd = 5'(d);
        rr = 5'(r);
        return {(carry ? 6'b000111 : 6'b000011), rr[4], dd[4], dd[3:0], rr[3:0]};
    endfunction

    // Drive one word at a falling edge, then check at the next falling edge.
    task automatic apply(input bit carry, input int d, input int r,
                         input int a, input int b, input int s, input string tag);
        int cin, sum, res, h, v, n, z, c, sg, exps;
        @(negedge clk);
        instr_valid = 1'b1;
        instr   = mk(carry, d, r);
        rd_val  = 8'(a);
        rr_val  = 8'(b);
        sreg_in = 8'(s);
        @(negedge clk);
        instr_valid = 1'b0;
        cin = (carry && ((s & 1) != 0)) ? 1 : 0;
        sum = (a & 255) + (b & 255) + cin;
        res = sum % 256;
        c   = (sum > 255) ? 1 : 0;
        h   = (((a & 15) + (b & 15) + cin) > 15) ? 1 : 0;
        n   = (res >= 128) ? 1 : 0;
        v   = ((((a & 255) >= 128) == ((b & 255) >= 128)) &&
               (((a & 255) >= 128) != (n == 1))) ? 1 : 0;
        z   = (res == 0) ? 1 : 0;
        sg  = n ^ v;
        exps = (s & 8'hC0) | (h << 5) | (sg << 4) | (v << 3) | (n << 2) | (z << 1) | c;
        chk({"R3 valid ", tag}, int'(res_valid), 1);
        chk({"R3 result ", tag}, int'(res_data), res);
        chk({"R4 carry ", tag}, int'(sreg_out[0]), c);
        chk({"R5 zero ", tag}, int'(sreg_out[1]), z);
        chk({"R6 neg/ovf ", tag}, int'(sreg_out[3:2]), (v << 1) | n);
        chk({"R7 sign ", tag}, int'(sreg_out[4]), sg);
        chk({"R8 half ", tag}, int'(sreg_out[5]), h);
        chk({"R9 I/T ", tag}, int'(sreg_out[7:6]), (s >> 6) & 3);
        chk({"R2 dst ", tag}, int'(dst_idx), d & 31);
        chk({"R2 src ", tag}, int'(src_idx), r & 31);
        chk({"R10 pc_step ", tag}, int'(pc_step), 1);
        chk({"R1 sreg_wr ", tag}, int'(sreg_wr), 1);
        last_res  = 8'(res);
        last_sreg = 8'(exps);
        chk({"R1 status byte ", tag}, int'(sreg_out), exps);
    endtask

    task automatic reject(input logic [15:0] w, input bit vld, input string tag);
        @(negedge clk);
        instr_valid = vld;
        instr   = w;
        rd_val  = 8'h5A;
        rr_val  = 8'hA7;
        sreg_in = 8'hFF;
        @(negedge clk);
        instr_valid = 1'b0;
        chk({"R11 res_valid ", tag}, int'(res_valid), 0);
        chk({"R11 sreg_wr ", tag}, int'(sreg_wr), 0);
        chk({"R11 pc_step ", tag}, int'(pc_step), 0);
        chk({"R11 res_data held ", tag}, int'(res_data), int'(last_res));
        chk({"R11 sreg held ", tag}, int'(sreg_out), int'(last_sreg));
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 res_valid", int'(res_valid), 0);
        chk("R12 sreg_wr", int'(sreg_wr), 0);
        chk("R12 pc_step", int'(pc_step), 0);
        chk("R12 res_data", int'(res_data), 0);
        chk("R12 sreg_out", int'(sreg_out), 0);
        chk("R12 idx", int'({dst_idx, src_idx}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 after release", int'(res_valid), 0);

        apply(0, 0, 1, 8'h00, 8'h00, 8'h00, "zero");
        apply(0, 17, 5, 8'h0F, 8'h01, 8'h00, "half");
        apply(0, 31, 16, 8'h7F, 8'h01, 8'hC0, "ovf pos");
        apply(0, 16, 31, 8'h80, 8'h80, 8'h40, "ovf neg");
        apply(0, 3, 29, 8'hFF, 8'h01, 8'h80, "wrap");
        apply(0, 9, 2, 8'hFF, 8'h00, 8'h01, "R1 plain ignores C");
        apply(1, 9, 2, 8'hFF, 8'h00, 8'h01, "R1 carry wrap");
        apply(1, 20, 11, 8'h07, 8'h08, 8'hC1, "R8 carry into bit 4");
        apply(1, 4, 4, 8'h3C, 8'h3C, 8'h00, "R1 carry clear");
        apply(0, 22, 22, 8'h81, 8'h81, 8'h00, "R13 shift");
        apply(0, 7, 7, 8'h48, 8'h48, 8'h00, "R13 shift ovf");

        reject(16'h2C00, 1'b1, "neighbour opcode");
        reject(16'h0800, 1'b1, "near prefix");
        reject(16'h1800, 1'b1, "near carry prefix");
        reject(16'h0C00, 1'b0, "idle");

        for (int i = 0; i < 300; i++) begin
            apply(bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)),
                  int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), "random");
        end

        // R10: strobe lasts one cycle only
        @(negedge clk);
        chk("R10 single pulse", int'(pc_step), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule